// File: doc/BRIEF.md
# FIFO-Buffered Left-Justified Audio Serializer

This block takes parallel stereo samples from an upsampling filter and turns them into a serial audio stream for a downstream transmitter. The left and right words arrive together on a single write strobe and are stored side by side in one two-lane sample FIFO. The block starts output only once that FIFO has filled to half its depth. From then on it draws one stereo pair per output frame, so the buffer sits near its midpoint and can absorb rate jitter in either direction.

The block runs on a master clock at 128 times the output sample rate and generates its own bit clock and word clock. Each frame holds 64 bit periods and two 32-bit slots, left first. Each slot carries a 24-bit sample, most significant bit first, followed by zero padding.

Loss of receiver lock, a clear request or reset empties the FIFO and silences the outputs. Each of them also re-arms the half-full wait. Two sticky flags report problems. One records a write that found the FIFO full. The other records a frame that found the FIFO empty.

Top module: `lj_serializer`

## Requirements
- R1: A write stores `wr_left` and `wr_right` as one pair, and pairs are played out in write order with their left/right pairing kept.
- R2: The FIFO holds DEPTH pairs (512 by default). A write that arrives while DEPTH pairs are stored is dropped and sets `overflow`, which stays high until the next flush.
- R3: While `rx_lock` is low, the FIFO is held empty, `bclk`, `wclk` and `sdata` are low, and both flags are clear. A flush is any of `rst`, `clr_req` or low `rx_lock`.
- R4: After a flush, no bit clock is produced until `fifo_level` has reached DEPTH/2. Playout then begins two cycles later with the first pair taken from the FIFO.
- R5: Each frame carries 24 left data bits, 8 zero bits, 24 right data bits and 8 zero bits, in that order.
- R6: Each channel is sent MSB first, and its MSB occupies the first bit period after the word clock edge.
- R7: During playout, `bclk` alternates low and high on successive master clock cycles, starting low. `wclk` is high for bit periods 0 to 31 (left) and low for 32 to 63 (right), and it changes only while `bclk` is low.
- R8: A one-cycle `clr_req` pulse empties the FIFO, clears both flags, returns the outputs to idle and restarts the half-full wait.
- R9: If the FIFO is empty when the next frame's pair is fetched (master cycle 125 of 128), that frame is sent as all zeros and `underflow` is set until the next flush.
- R10: Exactly one pair is removed per 128-cycle frame during playout, and `fifo_level` always equals the number of stored pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 128 times the output sample rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_lock | input | 1 | Receiver lock; low holds the block flushed |
| clr_req | input | 1 | Synchronous clear request, one cycle |
| wr_en | input | 1 | Write strobe for one stereo pair |
| wr_left | input | SAMPLE_W (24) | Left sample |
| wr_right | input | SAMPLE_W (24) | Right sample |
| sdata | output | 1 | Left-justified serial data |
| bclk | output | 1 | Bit clock, master clock divided by two |
| wclk | output | 1 | Word clock, high for the left channel |
| fifo_level | output | clog2(DEPTH)+1 (10) | Number of stored pairs |
| underflow | output | 1 | Sticky: a frame found the FIFO empty |
| overflow | output | 1 | Sticky: a write was dropped because the FIFO was full |

## Verification
Every result is a register, so each output shows the effect of the inputs sampled at one rising edge by the following falling edge. The bench's behavioural queue model advances at each rising edge from the same inputs. It is compared with the block at each falling edge, which keeps every check in that single-edge window.

The model mirrors the timing rules stated in the requirements:
- Playout starts two edges after the level first reaches half.
- The next pair is fetched at frame cycle 125, and the new frame is loaded at cycle 127.
- A flush takes effect one edge after it is sampled.

Directed checks taken at the same falling edge cover the half-full wait, clear and lock loss.

// File: rtl/lj_ser_pkg.sv
package lj_ser_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2
  } play_st_e;

  function automatic int frame_ticks(input int slot_w);
    return 4 * slot_w;
  endfunction

endpackage

// File: rtl/lj_pair_fifo.sv
module lj_pair_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 512,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             overflow
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_ok, rd_ok;

  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign wr_ok = wr_en && !full && !flush;
  assign rd_ok = rd_en && !empty && !flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so a block RAM can hold it
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
    if (rd_ok) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  p_full_drops_r2: assert property (@(posedge clk) disable iff (rst)
    (!flush && full && wr_en && !rd_en) |=> full);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0 && !overflow));

endmodule

// File: rtl/lj_frame_seq.sv
module lj_frame_seq
  import lj_ser_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int DEPTH  = 512,
  localparam int LVL_W    = $clog2(DEPTH) + 1,
  localparam int TICKS    = frame_ticks(SLOT_W),
  localparam int PH_W     = $clog2(TICKS),
  localparam int LAST     = TICKS - 1,
  localparam int MID      = 2 * SLOT_W - 1,
  localparam int PREFETCH = LAST - 2,
  localparam int HALF     = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_empty,
  output logic             rd_en,
  output logic             ld_left,
  output logic             ld_right,
  output logic             shift_en,
  output logic             pair_valid,
  output logic             bclk,
  output logic             wclk,
  output logic             underflow
);

  play_st_e        st, st_n;
  logic [PH_W-1:0] ph, ph_n;
  logic            pop_ok;
  logic            at_last, at_mid, at_fetch, running;

  assign running  = (st == ST_RUN);
  assign at_last  = running && (ph == PH_W'(LAST));
  assign at_mid   = running && (ph == PH_W'(MID));
  assign at_fetch = running && (ph == PH_W'(PREFETCH));

  assign rd_en = !flush &&
                 (((st == ST_WAIT) && (fifo_level >= LVL_W'(HALF))) ||
                  (at_fetch && !fifo_empty));

  assign ld_left    = (st == ST_PRIME) || at_last;
  assign ld_right   = at_mid;
  assign shift_en   = running && ph[0] && !at_last && !at_mid;
  assign pair_valid = (st == ST_PRIME) || pop_ok;

  always_comb begin
    st_n = st;
    ph_n = ph;
    unique case (st)
      ST_WAIT:  if (fifo_level >= LVL_W'(HALF)) st_n = ST_PRIME;
      ST_PRIME: begin
        st_n = ST_RUN;
        ph_n = '0;
      end
      ST_RUN:   ph_n = at_last ? '0 : ph + 1'b1;
      default:  st_n = ST_WAIT;
    endcase
    if (flush) begin
      st_n = ST_WAIT;
      ph_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    st   <= st_n;
    ph   <= ph_n;
    bclk <= (st_n == ST_RUN) && ph_n[0];
    wclk <= (st_n == ST_RUN) && (ph_n <= PH_W'(MID));
    if (flush) begin
      pop_ok    <= 1'b0;
      underflow <= 1'b0;
    end else if (at_fetch) begin
      pop_ok <= !fifo_empty;
      if (fifo_empty) underflow <= 1'b1;
    end
  end

  p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !fifo_empty);

  p_start_at_half_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PRIME) |-> ($past(fifo_level) >= LVL_W'(HALF)));

  p_bclk_alternates_r7: assert property (@(posedge clk) disable iff (rst)
    bclk |=> !bclk);

  p_wclk_on_low_bclk_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(wclk) |-> !bclk);

endmodule

// File: rtl/lj_slot_shifter.sv
module lj_slot_shifter #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  localparam int PAD     = SLOT_W - SAMPLE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  ld_left,
  input  logic                  ld_right,
  input  logic                  shift_en,
  input  logic                  pair_valid,
  input  logic [2*SAMPLE_W-1:0] pair,
  output logic                  sdata
);

  logic [SLOT_W-1:0]   shreg;
  logic [SAMPLE_W-1:0] right_hold;

  assign sdata = shreg[SLOT_W-1];

  always_ff @(posedge clk) begin
    if (flush) begin
      shreg      <= '0;
      right_hold <= '0;
    end else if (ld_left) begin
      shreg      <= pair_valid ? {pair[2*SAMPLE_W-1:SAMPLE_W], {PAD{1'b0}}} : '0;
      right_hold <= pair_valid ? pair[SAMPLE_W-1:0] : '0;
    end else if (ld_right) begin
      shreg <= {right_hold, {PAD{1'b0}}};
    end else if (shift_en) begin
      shreg <= {shreg[SLOT_W-2:0], 1'b0};
    end
  end

  p_load_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    $countones({ld_left, ld_right, shift_en}) <= 1);

  p_shift_keeps_pad_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_right && !flush) |=> (shreg[PAD-1:0] == '0));

endmodule

// File: rtl/lj_serializer.sv
module lj_serializer #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int DEPTH    = 512,
  localparam int LVL_W   = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_lock,
  input  logic                clr_req,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_left,
  input  logic [SAMPLE_W-1:0] wr_right,
  output logic                sdata,
  output logic                bclk,
  output logic                wclk,
  output logic [LVL_W-1:0]    fifo_level,
  output logic                underflow,
  output logic                overflow
);

  logic                  flush;
  logic                  rd_en, fifo_empty, fifo_full;
  logic [2*SAMPLE_W-1:0] rd_pair;
  logic                  ld_left, ld_right, shift_en, pair_valid;

  assign flush = rst || clr_req || !rx_lock;

  lj_pair_fifo #(.W(2 * SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .wr_en    (wr_en),
    .wr_data  ({wr_left, wr_right}),
    .rd_en    (rd_en),
    .rd_data  (rd_pair),
    .level    (fifo_level),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .overflow (overflow)
  );

  lj_frame_seq #(.SLOT_W(SLOT_W), .DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .fifo_level (fifo_level),
    .fifo_empty (fifo_empty),
    .rd_en      (rd_en),
    .ld_left    (ld_left),
    .ld_right   (ld_right),
    .shift_en   (shift_en),
    .pair_valid (pair_valid),
    .bclk       (bclk),
    .wclk       (wclk),
    .underflow  (underflow)
  );

  lj_slot_shifter #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .ld_left    (ld_left),
    .ld_right   (ld_right),
    .shift_en   (shift_en),
    .pair_valid (pair_valid),
    .pair       (rd_pair),
    .sdata      (sdata)
  );

  p_unlocked_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !rx_lock |=> (!bclk && !wclk && !sdata && fifo_level == '0 && !underflow));

  p_full_not_exceeded_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_full |=> (fifo_level <= $past(fifo_level)));

endmodule

// File: tb/test_lj_serializer.sv
module test_lj_serializer;

  localparam int SW    = 24;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_lock = 1'b0;
  logic          clr_req = 1'b0;
  logic          wr_en = 1'b0;
  logic [SW-1:0] wr_left = '0;
  logic [SW-1:0] wr_right = '0;
  logic          sdata, bclk, wclk, underflow, overflow;
  logic [LW-1:0] fifo_level;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  bit started = 0;

  always #10 clk = ~clk;

  lj_serializer #(.SAMPLE_W(SW), .SLOT_W(32), .DEPTH(DEPTH)) i_lj_serializer (
    .clk(clk), .rst(rst), .rx_lock(rx_lock), .clr_req(clr_req),
    .wr_en(wr_en), .wr_left(wr_left), .wr_right(wr_right),
    .sdata(sdata), .bclk(bclk), .wclk(wclk), .fifo_level(fifo_level),
    .underflow(underflow), .overflow(overflow)
  );

  // behavioural reference
  logic [47:0] q[$];
  int          m_st = 0;
  int          m_ph = 0;
  logic [63:0] m_frame = '0;
  logic [47:0] m_pend = '0;
  bit          m_pop_ok = 0;
  bit          m_uf = 0;
  bit          m_of = 0;

  function automatic logic [63:0] mkframe(input logic [47:0] p, input bit v);
    return v ? {p[47:24], 8'h00, p[23:0], 8'h00} : 64'h0;
  endfunction

  always @(posedge clk) begin : model
    int sz;
    bit push_ok;
    sz = q.size();
    started = 1;
    if (rst || clr_req || !rx_lock) begin
      q.delete();
      m_st = 0; m_ph = 0; m_frame = '0; m_pop_ok = 0; m_uf = 0; m_of = 0;
    end else begin
      push_ok = wr_en && (sz < DEPTH);
      if (wr_en && sz >= DEPTH) m_of = 1;
      case (m_st)
        0: if (sz >= HALF) begin m_pend = q.pop_front(); m_st = 1; end
        1: begin m_frame = mkframe(m_pend, 1); m_ph = 0; m_st = 2; end
        default: begin
          if (m_ph == 125) begin
            if (sz > 0) begin m_pend = q.pop_front(); m_pop_ok = 1; end
            else begin m_pop_ok = 0; m_uf = 1; end
          end
          if (m_ph == 127) begin m_frame = mkframe(m_pend, m_pop_ok); m_ph = 0; end
          else m_ph = m_ph + 1;
        end
      endcase
      if (push_ok) q.push_back({wr_left, wr_right});
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      bit eb, ew, es;
      eb = (m_st == 2) && m_ph[0];
      ew = (m_st == 2) && (m_ph < 64);
      es = (m_st == 2) && m_frame[63 - m_ph / 2];
      chk("R1 R5 R6 sdata", sdata, es);
      chk("R7 bclk", bclk, eb);
      chk("R7 wclk", wclk, ew);
      chk("R2 R10 fifo_level", fifo_level, q.size());
      chk("R9 underflow", underflow, m_uf);
      chk("R2 overflow", overflow, m_of);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic put_pair(input logic [SW-1:0] l, input logic [SW-1:0] r);
    wr_en = 1'b1; wr_left = l; wr_right = r;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic finish_run;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(3);
    @(negedge clk);
    chk("R3 idle while unlocked", {bclk, wclk, sdata, underflow, overflow}, 5'b0);
    step(0);
    rx_lock = 1'b1;
    step(2);
    for (int i = 0; i < HALF - 1; i++) put_pair(24'h100000 + i, 24'h200000 + i);
    step(200);
    @(negedge clk);
    chk("R4 no bit clock below half", bclk, 0);
    step(0);
    put_pair(24'hFFFFFF, 24'h000000);
    put_pair(24'hA5A5A5, 24'h5A5A5A);
    step(2);
    @(negedge clk);
    chk("R4 playout started", i_lj_serializer.bclk | i_lj_serializer.wclk, 1);
    step(0);
    for (int i = 0; i < 6; i++) begin
      put_pair(24'h800001 ^ (i << 4), $urandom() & 24'hFFFFFF);
      step(127);
    end
    // burst past capacity (R2)
    for (int i = 0; i < 14; i++) put_pair(24'h0F0F00 + i, 24'hF0F000 + i);
    step(300);
    // drain until empty (R9)
    step(DEPTH * 128 + 400);
    // clear request (R8)
    clr_req = 1'b1;
    step(1);
    clr_req = 1'b0;
    @(negedge clk);
    chk("R8 cleared", {fifo_level, underflow, overflow, bclk}, '0);
    step(0);
    for (int i = 0; i < HALF; i++) put_pair(24'h345678 + i, 24'h876543 - i);
    for (int i = 0; i < 4; i++) begin
      put_pair(24'h7FFFFF, 24'h800000);
      step(127);
    end
    step(40);
    rx_lock = 1'b0;
    step(3);
    @(negedge clk);
    chk("R3 lock loss idles", {bclk, wclk, sdata, fifo_level}, '0);
    step(0);
    rx_lock = 1'b1;
    step(20);
    finish_run();
  end

endmodule